// File: doc/BRIEF.md
# Wake Packet Matcher

This block sits behind an on-off-keyed envelope detector in a radio that sleeps most of the time. It takes the recovered serial chip stream and samples one chip on each falling edge of the bit clock. While idle it searches for a fixed start pattern that is sent without line coding. Once the pattern has been seen, it decodes the 92 Manchester chips that follow into 46 payload bits. The payload carries, most significant bit first, an 8-bit node address, then a 26-bit application identifier, then a 12-bit channel identifier.

When both the address and the application identifier equal the values configured for this node, the block copies the channel identifier to its outputs and pulses a wake request. The channel identifier is made of a 4-bit band field and an 8-bit channel-select field. A chip pair that is not a legal Manchester symbol ends the packet at once and raises a one-cycle error pulse. Whatever way a packet ends, the block goes back to searching for the start pattern.

Top module: `wake_packet_matcher`

## Requirements
- R1: While `rstN` is low, and after it is released until a packet is accepted, `wakeMatch`, `decodeErr`, `chanBand` and `chanSelect` are all zero.
- R2: Chips are sampled on falling edges of `bitClk`. Decoding starts only after the last eight sampled chips equal 8'hA7, oldest chip in bit 7. A different 8-chip prefix in front of a payload produces no wake and no error.
- R3: A payload bit is sent as two chips. A 0 is the chip 1 followed by the chip 0, and a 1 is the chip 0 followed by the chip 1. Exactly 92 payload chips follow the start pattern.
- R4: A chip pair of 00 or 11 at any payload position makes `decodeErr` high for exactly one bit period. That period starts at the falling edge that samples the second chip of the bad pair. The packet is abandoned, with no wake.
- R5: The payload holds, in this order and MSB first, the address (8 bits), the application ID (26 bits) and the channel ID (12 bits). When the address equals `localAddr` and the application ID equals `localAppId`, `wakeMatch` is high for exactly one bit period, starting at the falling edge that samples chip 92. At that same edge `chanBand` takes channel ID bits 11..8 and `chanSelect` takes bits 7..0.
- R6: A packet whose address differs from `localAddr` gives no wake pulse and leaves the channel outputs unchanged.
- R7: A packet whose application ID differs from `localAppId` gives no wake pulse and leaves the channel outputs unchanged.
- R8: `chanBand` and `chanSelect` change only at a falling edge where a wake pulse begins. They hold their value through mismatches and errors.
- R9: After any packet ends, whether by match, mismatch or error, the block searches for a fresh start pattern. A second packet sent right behind the first is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; chips are sampled on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Demodulated chip stream |
| localAddr | input | 8 | Address configured for this node |
| localAppId | input | 26 | Application identifier configured for this node |
| chanBand | output | 4 | Band field of the last accepted channel ID |
| chanSelect | output | 8 | Channel-select field of the last accepted channel ID |
| wakeMatch | output | 1 | One-period pulse when a packet fully matches |
| decodeErr | output | 1 | One-period pulse on an illegal Manchester pair |

## Verification
The bound assertions check, on every cycle, the properties that hold regardless of packet content:
- the wake and error pulses never occur together;
- each pulse lasts exactly one bit period;
- the channel outputs stay stable unless a wake pulse begins.

Only the bench scenarios can show the rest. This covers the exact timing of each pulse relative to the packet's last chip, and field order and bit placement inside the 92-chip payload. It also covers the rejection of near-miss start patterns and of single-field mismatches, recovery after an error, and decoding of back-to-back packets.

// File: rtl/wake_pkg.sv
package wake_pkg;

  // Default raw start pattern that precedes every packet.
  localparam logic [7:0] START_PATTERN_DEFAULT = 8'hA7;

  typedef enum logic {
    ST_HUNT,
    ST_PAYLOAD
  } rxState_e;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic clearHunt;    // empty the start-pattern window
    logic captureChip;  // remember the first chip of a pair
    logic shiftBit;     // push a decoded bit into the payload register
    logic loadChannel;  // copy the channel field to the outputs
  } rxStrobe_t;

endpackage

// File: rtl/wake_rx_datapath.sv
module wake_rx_datapath
  import wake_pkg::*;
#(
  parameter int unsigned START_W = 8,
  parameter logic [START_W-1:0] START_PAT = START_PATTERN_DEFAULT,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned APP_W = 26,
  parameter int unsigned BAND_W = 4,
  parameter int unsigned SEL_W = 8
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic [APP_W-1:0]  localAppId,
  input  rxStrobe_t         strobe,
  output logic              startHit,
  output logic              firstChip,
  output logic              fieldsMatch,
  output logic [BAND_W-1:0] chanBand,
  output logic [SEL_W-1:0]  chanSelect
);

  localparam int unsigned CHAN_W = BAND_W + SEL_W;
  localparam int unsigned PAY_W  = ADDR_W + APP_W + CHAN_W;

  logic [START_W-1:0] huntWin;
  logic [START_W-1:0] huntNext;
  logic [PAY_W-1:0]   payloadQ;
  logic [PAY_W-1:0]   payloadNext;
  logic [ADDR_W-1:0]  rxAddr;
  logic [APP_W-1:0]   rxApp;
  logic [CHAN_W-1:0]  rxChan;

  // Start-pattern window: the newest chip enters at bit 0.
  assign huntNext = {huntWin[START_W-2:0], serialIn};
  assign startHit = (huntNext == START_PAT);

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      huntWin <= '0;
    end else if (strobe.clearHunt) begin
      huntWin <= '0;
    end else begin
      huntWin <= huntNext;
    end
  end

  // First chip of the current Manchester pair.
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      firstChip <= 1'b0;
    end else if (strobe.captureChip) begin
      firstChip <= serialIn;
    end
  end

  // The second chip of a legal pair equals the decoded bit.
  assign payloadNext = {payloadQ[PAY_W-2:0], serialIn};

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      payloadQ <= '0;
    end else if (strobe.shiftBit) begin
      payloadQ <= payloadNext;
    end
  end

  // Field split of the payload once its last bit arrives.
  assign rxAddr = payloadNext[PAY_W-1 -: ADDR_W];
  assign rxApp  = payloadNext[CHAN_W +: APP_W];
  assign rxChan = payloadNext[CHAN_W-1:0];

  assign fieldsMatch = (rxAddr == localAddr) && (rxApp == localAppId);

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      chanBand   <= '0;
      chanSelect <= '0;
    end else if (strobe.loadChannel) begin
      chanBand   <= rxChan[CHAN_W-1 -: BAND_W];
      chanSelect <= rxChan[SEL_W-1:0];
    end
  end

endmodule

// File: rtl/wake_rx_control.sv
module wake_rx_control
  import wake_pkg::*;
#(
  parameter int unsigned PAY_W = 46
) (
  input  logic      bitClk,
  input  logic      rstN,
  input  logic      serialIn,
  input  logic      startHit,
  input  logic      firstChip,
  input  logic      fieldsMatch,
  output rxStrobe_t strobe,
  output logic      wakeMatch,
  output logic      decodeErr
);

  localparam int unsigned CHIPS = 2 * PAY_W;
  localparam int unsigned CNT_W = $clog2(CHIPS);
  localparam logic [CNT_W-1:0] LAST_CHIP = CNT_W'(CHIPS - 1);

  rxState_e        state;
  rxState_e        stateNext;
  logic [CNT_W-1:0] chipCnt;
  logic [CNT_W-1:0] chipCntNext;
  logic             setWake;
  logic             setErr;

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    chipCntNext = chipCnt;
    setWake     = 1'b0;
    setErr      = 1'b0;
    unique case (state)
      ST_HUNT: begin
        if (startHit) begin
          stateNext   = ST_PAYLOAD;
          chipCntNext = '0;
        end
      end
      ST_PAYLOAD: begin
        chipCntNext = chipCnt + 1'b1;
        if (!chipCnt[0]) begin
          strobe.captureChip = 1'b1;
        end else if (firstChip == serialIn) begin
          // Pair 00 or 11 is not a Manchester symbol.
          setErr           = 1'b1;
          strobe.clearHunt = 1'b1;
          stateNext        = ST_HUNT;
        end else begin
          strobe.shiftBit = 1'b1;
          if (chipCnt == LAST_CHIP) begin
            strobe.clearHunt = 1'b1;
            stateNext        = ST_HUNT;
            if (fieldsMatch) begin
              strobe.loadChannel = 1'b1;
              setWake            = 1'b1;
            end
          end
        end
      end
      default: stateNext = ST_HUNT;
    endcase
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      chipCnt   <= '0;
      wakeMatch <= 1'b0;
      decodeErr <= 1'b0;
    end else begin
      state     <= stateNext;
      chipCnt   <= chipCntNext;
      wakeMatch <= setWake;
      decodeErr <= setErr;
    end
  end

endmodule

// File: rtl/wake_packet_matcher.sv
module wake_packet_matcher
  import wake_pkg::*;
#(
  parameter int unsigned START_W = 8,
  parameter logic [START_W-1:0] START_PAT = START_PATTERN_DEFAULT,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned APP_W = 26,
  parameter int unsigned BAND_W = 4,
  parameter int unsigned SEL_W = 8
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic [APP_W-1:0]  localAppId,
  output logic [BAND_W-1:0] chanBand,
  output logic [SEL_W-1:0]  chanSelect,
  output logic              wakeMatch,
  output logic              decodeErr
);

  localparam int unsigned PAY_W = ADDR_W + APP_W + BAND_W + SEL_W;

  rxStrobe_t strobe;
  logic      startHit;
  logic      firstChip;
  logic      fieldsMatch;

  wake_rx_control #(
    .PAY_W(PAY_W)
  ) u_ctrl (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .startHit   (startHit),
    .firstChip  (firstChip),
    .fieldsMatch(fieldsMatch),
    .strobe     (strobe),
    .wakeMatch  (wakeMatch),
    .decodeErr  (decodeErr)
  );

  wake_rx_datapath #(
    .START_W  (START_W),
    .START_PAT(START_PAT),
    .ADDR_W   (ADDR_W),
    .APP_W    (APP_W),
    .BAND_W   (BAND_W),
    .SEL_W    (SEL_W)
  ) u_dp (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .localAddr  (localAddr),
    .localAppId (localAppId),
    .strobe     (strobe),
    .startHit   (startHit),
    .firstChip  (firstChip),
    .fieldsMatch(fieldsMatch),
    .chanBand   (chanBand),
    .chanSelect (chanSelect)
  );

endmodule

// File: rtl/wake_rx_checker.sv
module wake_rx_checker #(
  parameter int unsigned BAND_W = 4,
  parameter int unsigned SEL_W = 8
) (
  input logic              bitClk,
  input logic              rstN,
  input logic [BAND_W-1:0] chanBand,
  input logic [SEL_W-1:0]  chanSelect,
  input logic              wakeMatch,
  input logic              decodeErr
);

  // R4
  wake_err_exclusive_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    !(wakeMatch && decodeErr));

  // R5
  wake_single_pulse_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    wakeMatch |=> !wakeMatch);

  // R4
  err_single_pulse_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    decodeErr |=> !decodeErr);

  // R8
  chan_hold_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    !wakeMatch |-> $stable({chanBand, chanSelect}));

endmodule

bind wake_packet_matcher wake_rx_checker #(
  .BAND_W(BAND_W),
  .SEL_W (SEL_W)
) u_chk (
  .bitClk    (bitClk),
  .rstN      (rstN),
  .chanBand  (chanBand),
  .chanSelect(chanSelect),
  .wakeMatch (wakeMatch),
  .decodeErr (decodeErr)
);

// File: tb/tb_wake_packet_matcher.sv
module tb_wake_packet_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int PKT_CHIPS  = 100;
  localparam logic [7:0]  MY_ADDR = 8'h3C;
  localparam logic [25:0] MY_APP  = 26'h2A5_5F0C;

  logic        bitClk = 1'b0;
  logic        rstN;
  logic        serialIn;
  logic [7:0]  localAddr;
  logic [25:0] localAppId;
  logic [3:0]  chanBand;
  logic [7:0]  chanSelect;
  logic        wakeMatch;
  logic        decodeErr;

  int checks = 0;
  int errors = 0;
  logic [3:0] expBand = '0;
  logic [7:0] expSel  = '0;

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  wake_packet_matcher dut (
    .bitClk    (bitClk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .localAddr (localAddr),
    .localAppId(localAppId),
    .chanBand  (chanBand),
    .chanSelect(chanSelect),
    .wakeMatch (wakeMatch),
    .decodeErr (decodeErr)
  );

  // Builds a full packet: raw start pattern, then Manchester chips (0 -> 10, 1 -> 01).
  function automatic logic [PKT_CHIPS-1:0] buildPacket(input logic [7:0] a, input logic [25:0] app,
                                                       input logic [3:0] b, input logic [7:0] s,
                                                       input logic [7:0] startPat);
    logic [45:0] pay;
    logic [91:0] enc;
    pay = {a, app, b, s};
    for (int i = 0; i < 46; i++) begin
      enc[2*i+1 -: 2] = pay[i] ? 2'b01 : 2'b10;
    end
    return {startPat, enc};
  endfunction

  task automatic checkVal(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendChip(input logic c);
    @(posedge bitClk);
    serialIn = c;
  endtask

  // Sends chips from index 99 down to lowIdx.
  task automatic sendChips(input logic [PKT_CHIPS-1:0] pkt, input int lowIdx);
    for (int i = PKT_CHIPS-1; i >= lowIdx; i--) sendChip(pkt[i]);
  endtask

  // Samples the outputs during the bit period after the last chip, then one period later.
  task automatic checkOutcome(input string req, input logic expWake, input logic expErr);
    @(posedge bitClk);
    serialIn = 1'b0;
    #1;
    checkVal(req, "wakeMatch", 32'(wakeMatch), 32'(expWake));
    checkVal(req, "decodeErr", 32'(decodeErr), 32'(expErr));
    checkVal(req, "chanBand", 32'(chanBand), 32'(expBand));
    checkVal(req, "chanSelect", 32'(chanSelect), 32'(expSel));
    @(posedge bitClk);
    #1;
    checkVal(req, "pulse end wake", 32'(wakeMatch), 32'd0);
    checkVal(req, "pulse end err", 32'(decodeErr), 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendChip(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PKT_CHIPS-1:0] pkt;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0;
    serialIn = 1'b0;
    localAddr = MY_ADDR;
    localAppId = MY_APP;
    repeat (3) @(posedge bitClk);
    #1;
    // R1 reset state
    checkVal("R1", "wakeMatch", 32'(wakeMatch), 32'd0);
    checkVal("R1", "decodeErr", 32'(decodeErr), 32'd0);
    checkVal("R1", "channel", 32'({chanBand, chanSelect}), 32'd0);
    @(posedge bitClk);
    rstN = 1'b1;
    idle(4);
    #1;
    checkVal("R1", "channel after release", 32'({chanBand, chanSelect}), 32'd0);

    // R2 R3 R5: directed match
    pkt = buildPacket(MY_ADDR, MY_APP, 4'hB, 8'h5D, 8'hA7);
    sendChips(pkt, 0);
    expBand = 4'hB; expSel = 8'h5D;
    checkOutcome("R5", 1'b1, 1'b0);

    // R6: address mismatch by one bit
    idle(3);
    pkt = buildPacket(MY_ADDR ^ 8'h01, MY_APP, 4'h2, 8'h11, 8'hA7);
    sendChips(pkt, 0);
    checkOutcome("R6", 1'b0, 1'b0);

    // R7: application ID mismatch in its top bit
    idle(3);
    pkt = buildPacket(MY_ADDR, MY_APP ^ 26'h200_0000, 4'h3, 8'h22, 8'hA7);
    sendChips(pkt, 0);
    checkOutcome("R7", 1'b0, 1'b0);

    // R2: near-miss start pattern, payload would otherwise match
    idle(3);
    pkt = buildPacket(MY_ADDR, MY_APP, 4'h4, 8'h44, 8'hA6);
    sendChips(pkt, 0);
    checkOutcome("R2", 1'b0, 1'b0);

    // R4: pair 11 in first payload bit
    idle(3);
    pkt = buildPacket(MY_ADDR, MY_APP, 4'h5, 8'h55, 8'hA7);
    pkt[91 -: 2] = 2'b11;
    sendChips(pkt, 90);
    checkOutcome("R4", 1'b0, 1'b1);

    // R4: pair 00 in last payload bit, channel must hold (R8)
    idle(3);
    pkt = buildPacket(MY_ADDR, MY_APP, 4'h6, 8'h66, 8'hA7);
    pkt[1:0] = 2'b00;
    sendChips(pkt, 0);
    checkOutcome("R8", 1'b0, 1'b1);

    // R9: recovery, then two packets back to back
    idle(2);
    pkt = buildPacket(MY_ADDR, MY_APP, 4'h1, 8'hE1, 8'hA7);
    sendChips(pkt, 0);
    pkt = buildPacket(MY_ADDR, MY_APP, 4'hF, 8'h0F, 8'hA7);
    sendChips(pkt, 0);
    expBand = 4'hF; expSel = 8'h0F;
    checkOutcome("R9", 1'b1, 1'b0);

    // R3 R5 R6 R7 R8: random packets
    for (int n = 0; n < 40; n++) begin
      logic [7:0]  a;
      logic [25:0] app;
      logic [3:0]  b;
      logic [7:0]  s;
      int kind;
      int bad;
      a   = MY_ADDR;
      app = MY_APP;
      b   = 4'($urandom);
      s   = 8'($urandom);
      kind = int'($urandom % 4);
      if (kind == 1) a   = a ^ (8'd1 << ($urandom % 8));
      if (kind == 2) app = app ^ (26'd1 << ($urandom % 26));
      pkt = buildPacket(a, app, b, s, 8'hA7);
      idle(int'($urandom % 4) + 1);
      if (kind == 3) begin
        bad = int'($urandom % 46);
        pkt[2*bad+1 -: 2] = ($urandom % 2) ? 2'b11 : 2'b00;
        sendChips(pkt, 2*bad);
        checkOutcome("R4", 1'b0, 1'b1);
      end else begin
        sendChips(pkt, 0);
        if (kind == 0) begin
          expBand = b; expSel = s;
        end
        checkOutcome(kind == 0 ? "R5" : (kind == 1 ? "R6" : "R7"), kind == 0, 1'b0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule